// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies word addresses to a synchronous burst memory. A full address is captured from the address bus when either of two active-low load strobes is low at a rising clock edge: one strobe comes from the processor side and one from the memory-controller side. The captured address is presented at the first step of the burst. After that, each clock edge with the active-low advance input low moves a small burst counter one step. The counter has four positions by default, and every position gives the next address of the burst.

A static order-select input is captured together with the address. It chooses how the low address bits follow the counter. In the sequential order they count upward from the captured value and wrap. In the interleaved order they equal the captured low bits XOR the counter. The upper address bits never change inside a burst, so a wrap of the counter does not carry into them. The outputs are the composed address and the counter position. The memory array, the data path, the chip-enable decoding and the power modes sit in other blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While the active-low asynchronous reset is low, and after it is released, the address output is 0, the burst index is 0 and the order is sequential.
- R2: When either strobe is low at a rising edge, the address output after that edge equals the address input sampled at that edge, and the burst index is 0.
- R3: When both strobes are high and the advance input is low at a rising edge, the burst index after that edge is the previous index plus one, modulo 4.
- R4: When both strobes and the advance input are high at a rising edge, the address output and the burst index keep their values.
- R5: With the captured order-select at 0 (sequential), the low two address bits equal (captured low bits + burst index) mod 4.
- R6: With the captured order-select at 1 (interleaved), the low two address bits equal the captured low bits XOR the burst index.
- R7: The address bits above the low two stay equal to the captured address for the whole burst, including across a counter wrap.
- R8: When a strobe and the advance input are both low at the same edge, the load takes effect: the new address is captured and the burst index becomes 0.
- R9: The order-select input is sampled only at a load edge. Changing it between loads does not change the address output.
- R10: When both strobes are low at the same edge, one load takes place, the same as with either strobe alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_proc_n | input | 1 | Processor-side load strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 sequential, 1 interleaved (XOR) |
| addr_in | input | AW (16) | Address bus to be captured |
| addr_out | output | AW (16) | Current burst word address |
| burst_idx | output | CW (2) | Position within the burst |

## Verification
Two events can land on the same edge: a load from either strobe, and an advance of the counter. Some cycles drive a strobe and the advance input low together, and these cycles occur both in the middle of a burst and just before a counter wrap. The expected result is that the new address appears with index 0 and no increment. A behavioural model, built from integers, computes the expected address and index each cycle. It takes in stimulus that includes back-to-back loads, both strobes low together, and order-select changes in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic [AW-1:0] addr_in,
  input  logic          order_in,
  output logic [AW-1:0] base_q,
  output burst_order_e  order_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_SEQ;
    end else if (load_evt) begin
      base_q  <= addr_in;
      order_q <= burst_order_e'(order_in);
    end
  end

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(base_q) && $stable(order_q)));

  // R2
  base_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (base_q == $past(addr_in)));

endmodule

// File: rtl/burst_ctr.sv
module burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic          adv_evt,
  output logic [CW-1:0] idx_q,
  output logic          wrap_evt
);

  function automatic logic [CW-1:0] step_idx(input logic [CW-1:0] cur);
    return cur + CW'(1);
  endfunction

  assign wrap_evt = adv_evt && (idx_q == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_evt) begin
      idx_q <= '0;
    end else if (adv_evt) begin
      idx_q <= step_idx(idx_q);
    end
  end

  // R8
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (idx_q == '0));

  // R3
  adv_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && adv_evt) |=> (idx_q == $past(idx_q) + CW'(1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !adv_evt) |=> $stable(idx_q));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && wrap_evt) |=> (idx_q == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic [AW-1:0] base,
  input  burst_order_e  order,
  input  logic [CW-1:0] idx,
  output logic [AW-1:0] addr
);

  localparam int HW = AW - CW;

  function automatic logic [CW-1:0] seq_low(input logic [CW-1:0] b, input logic [CW-1:0] i);
    return b + i;
  endfunction

  function automatic logic [CW-1:0] xor_low(input logic [CW-1:0] b, input logic [CW-1:0] i);
    return b ^ i;
  endfunction

  logic [CW-1:0] low_bits;

  always_comb begin
    if (order == ORD_XOR) low_bits = xor_low(base[CW-1:0], idx);
    else                  low_bits = seq_low(base[CW-1:0], idx);
  end

  assign addr = {base[AW-1:CW], low_bits};

  // R7
  always_comb begin
    upper_pass_chk: assert (addr[AW-1:CW] == base[AW-1:CW]);
  end

  if (HW < 1) begin : g_bad_width
    initial $error("burst_order_map: AW must exceed CW");
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ads_proc_n,
  input  logic          ads_ctrl_n,
  input  logic          adv_n,
  input  logic          order_sel,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [CW-1:0] burst_idx
);

  logic          load_evt;
  logic          adv_evt;
  logic          wrap_evt;
  logic [AW-1:0] base_q;
  burst_order_e  order_q;

  assign load_evt = !ads_proc_n || !ads_ctrl_n;
  assign adv_evt  = !adv_n && !load_evt;

  burst_base_reg #(.AW(AW)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_evt(load_evt),
    .addr_in (addr_in),
    .order_in(order_sel),
    .base_q  (base_q),
    .order_q (order_q)
  );

  burst_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_evt(load_evt),
    .adv_evt (adv_evt),
    .idx_q   (burst_idx),
    .wrap_evt(wrap_evt)
  );

  burst_order_map #(.AW(AW), .CW(CW)) u_map (
    .base (base_q),
    .order(order_q),
    .idx  (burst_idx),
    .addr (addr_out)
  );

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_out == $past(addr_in)));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> (addr_out[AW-1:CW] == $past(addr_out[AW-1:CW])));

  // R4
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && adv_n) |=> $stable(addr_out));

  // R1
  always_comb begin
    if (!rst_n) reset_state_chk: assert (addr_out == '0 && burst_idx == '0);
  end

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  localparam int AW = 16;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads_proc_n = 1'b1;
  logic          ads_ctrl_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] burst_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_base = 0;
  int m_idx  = 0;
  int m_xor  = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.AW(AW), .CW(CW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .burst_idx (burst_idx)
  );

  function automatic int exp_addr();
    int lo;
    if (m_xor != 0) lo = (m_base % 4) ^ m_idx;
    else            lo = ((m_base % 4) + m_idx) % 4;
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic compare(input string tag);
    int ea;
    ea = exp_addr();
    checks++;
    if (int'(addr_out) != ea || int'(burst_idx) != m_idx) begin
      fails++;
      $display("FAIL %s: addr=%h idx=%0d expected addr=%h idx=%0d",
               tag, addr_out, burst_idx, ea[AW-1:0], m_idx);
    end
  endtask

  task automatic cyc(input bit ap, input bit ac, input bit av, input bit ord,
                     input int a, input string tag);
    ads_proc_n = ap;
    ads_ctrl_n = ac;
    adv_n      = av;
    order_sel  = ord;
    addr_in    = a[AW-1:0];
    @(posedge clk);
    if (!ap || !ac) begin
      m_base = a % 65536;
      m_idx  = 0;
      m_xor  = ord;
    end else if (!av) begin
      m_idx = (m_idx + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rng;
    rng = 32'h1234_5678;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2 processor strobe, R5 sequential burst with wrap, R7 no carry
    cyc(0, 1, 1, 0, 'hABCE, "R2 proc load");
    cyc(1, 1, 0, 0, 'h0000, "R5 step1");
    cyc(1, 1, 0, 0, 'h0000, "R7 wrap");
    cyc(1, 1, 0, 0, 'h0000, "R5 step3");
    cyc(1, 1, 0, 0, 'h0000, "R3 wrap to 0");
    // R4 hold with junk on address bus
    cyc(1, 1, 1, 1, 'h5555, "R4 idle hold");
    cyc(1, 1, 1, 0, 'hFFFF, "R4 idle hold 2");

    // R2 controller strobe, R6 interleaved
    cyc(1, 0, 1, 1, 'h1236, "R2 ctrl load");
    cyc(1, 1, 0, 1, 'h0000, "R6 step1");
    cyc(1, 1, 0, 1, 'h0000, "R6 step2");
    cyc(1, 1, 0, 1, 'h0000, "R6 step3");
    // R9 order input toggled mid burst
    cyc(1, 1, 0, 0, 'h0000, "R9 order ignored");
    cyc(1, 1, 1, 0, 'h0000, "R9 order ignored idle");

    // R8 strobe plus advance
    cyc(1, 1, 0, 0, 'h0000, "R3 advance");
    cyc(0, 1, 0, 0, 'h4441, "R8 proc load beats advance");
    cyc(1, 1, 0, 0, 'h0000, "R5 after R8");
    cyc(1, 1, 0, 0, 'h0000, "R5 after R8 b");
    cyc(1, 1, 0, 0, 'h0000, "R5 after R8 c");
    cyc(1, 0, 0, 1, 'h7773, "R8 ctrl load at wrap point");
    cyc(1, 1, 0, 1, 'h0000, "R6 after R8");

    // R10 both strobes, back to back loads
    cyc(0, 0, 1, 0, 'hFFFF, "R10 both strobes");
    cyc(1, 1, 0, 0, 'h0000, "R7 top address wrap");
    cyc(0, 0, 0, 1, 'h0002, "R10 both strobes plus advance");
    cyc(0, 1, 1, 0, 'h8001, "R2 back to back load");

    // mixed pseudo-random traffic
    for (int n = 0; n < 400; n++) begin
      bit ap, ac, av, od;
      rng = rng * 32'd1103515245 + 32'd12345;
      ap = (rng[20:18] != 3'd0);
      ac = (rng[23:21] != 3'd0);
      av = rng[24] & rng[25];
      av = ~av;
      od = rng[26];
      cyc(ap, ac, av, od, int'(rng[15:0]), "R3 R5 R6 mixed");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule